// File: doc/BRIEF.md
# Banked Accumulator and Flag Register Pair

This block keeps two complete working sets of an 8-bit accumulator together with its 8-bit flag byte. One set is the main pair and the other is the alternate pair. Exactly one of them is active at any time. The datapath writes results and flags into the active set through two write ports and reads the active set back on two outputs. The inactive set is left alone until it is selected again.

A single exchange strobe flips a one-bit bank pointer. No data is moved, so the accumulator and flag byte of a set always change over together, in one cycle. A small generator derives the zero and sign flags from an 8-bit result. When the update enable is set, an accumulator write also refreshes those two flag bits in the same pair and keeps the other six flag bits as they were.

Top module: `bankacc_top`

## Requirements
- R1: After reset the main pair is active (`alt_sel` = 0), and both accumulators and both flag bytes hold 0x00.
- R2: With `acc_we` high, `acc_wdata` is stored in the accumulator of the pair that is active in that cycle, and it appears on `acc_out` after the next rising edge.
- R3: With `flg_we` high, `flg_wdata` is stored in the flag byte of the active pair, and it appears on `flg_out` after the next rising edge.
- R4: Each cycle with `xchg` high inverts `alt_sel`, and the outputs switch to the other pair's stored values. Two exchanges in a row bring back the original pair unchanged.
- R5: The pair that is not selected keeps its accumulator and flag byte across any number of cycles and writes.
- R6: When a write and `xchg` happen in the same cycle, the write lands in the pair that was active before the exchange.
- R7: When `acc_we` and `upd_en` are high and `flg_we` is low, flag bit 6 (zero) of the target pair becomes 1 exactly when `acc_wdata` is 0x00.
- R8: Under the same conditions as R7, flag bit 7 (sign) becomes bit 7 of `acc_wdata`.
- R9: On a generated flag update, flag bits 5..0 keep their previous values. When `flg_we` and a generated update happen in the same cycle, `flg_wdata` wins.
- R10: An accumulator write with `upd_en` low leaves the flag byte unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| xchg | input | 1 | Exchange strobe; toggles the active pair |
| acc_we | input | 1 | Accumulator write enable |
| acc_wdata | input | 8 | Result to store in the accumulator |
| upd_en | input | 1 | Derive zero and sign flags from `acc_wdata` on an accumulator write |
| flg_we | input | 1 | Flag byte write enable |
| flg_wdata | input | 8 | Flag byte to store |
| acc_out | output | 8 | Accumulator of the active pair |
| flg_out | output | 8 | Flag byte of the active pair |
| alt_sel | output | 1 | 1 when the alternate pair is active |

## Verification
The vector walk mixes several kinds of write:
- Plain accumulator writes with flag update off show that the flag byte is untouched.
- Results of zero, negative and positive values separate the zero bit from the sign bit, and show that the other flag bits are kept.
- A cycle with both writes and the update on shows which source has priority.

Exchanges are tested three ways:
- Alone, to show the data is swapped rather than copied.
- Paired with writes, to show the write goes to the pair active before the swap.
- Back to back, to show two exchanges return to the original pair.

A reset in the middle of the run is checked on both banks, so a reset that cleared only the visible pair would be caught.

// File: rtl/bankacc_pkg.sv
package bankacc_pkg;
    localparam int DW       = 8;
    localparam int ZERO_BIT = 6;
    localparam int SIGN_BIT = 7;
    localparam int NBANK    = 2;

    typedef struct packed {
        logic [DW-1:0] acc;
        logic [DW-1:0] flg;
    } pair_t;
endpackage

// File: rtl/bankacc_flaggen.sv
module bankacc_flaggen
    import bankacc_pkg::*;
(
    input  logic [DW-1:0] result,
    output logic          zero_f,
    output logic          sign_f
);
    always_comb begin
        zero_f = (result == '0);
        sign_f = result[DW-1];
    end
endmodule

// File: rtl/bankacc_bank_sel.sv
module bankacc_bank_sel (
    input  logic clk,
    input  logic rst_n,
    input  logic xchg,
    output logic sel
);
    logic sel_d, sel_q;

    always_comb begin
        sel_d = sel_q;
        if (xchg) sel_d = ~sel_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sel_q <= 1'b0;
        else        sel_q <= sel_d;
    end

    assign sel = sel_q;

    AST_XCHG_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
        xchg |=> (sel_q != $past(sel_q)));   // R4
    AST_SEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !xchg |=> $stable(sel_q));           // R4
endmodule

// File: rtl/bankacc_pair.sv
module bankacc_pair
    import bankacc_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          acc_we,
    input  logic [DW-1:0] acc_wdata,
    input  logic          upd_en,
    input  logic          zero_f,
    input  logic          sign_f,
    input  logic          flg_we,
    input  logic [DW-1:0] flg_wdata,
    output pair_t         pair
);
    pair_t pair_d, pair_q;

    always_comb begin
        pair_d = pair_q;
        if (acc_we) begin
            pair_d.acc = acc_wdata;
            if (upd_en) begin
                pair_d.flg[ZERO_BIT] = zero_f;
                pair_d.flg[SIGN_BIT] = sign_f;
            end
        end
        if (flg_we) pair_d.flg = flg_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pair_q <= '0;
        else        pair_q <= pair_d;
    end

    assign pair = pair_q;

    AST_PAIR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!acc_we && !flg_we) |=> $stable(pair_q));              // R5
    AST_FLAG_PRIORITY: assert property (@(posedge clk) disable iff (!rst_n)
        flg_we |=> (pair_q.flg == $past(flg_wdata)));           // R9
    AST_FLAG_NO_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_we && !upd_en && !flg_we) |=> $stable(pair_q.flg)); // R10
    AST_LOW_BITS_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_we && upd_en && !flg_we) |=>
            (pair_q.flg[ZERO_BIT-1:0] == $past(pair_q.flg[ZERO_BIT-1:0]))); // R9
endmodule

// File: rtl/bankacc_top.sv
module bankacc_top
    import bankacc_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          xchg,
    input  logic          acc_we,
    input  logic [DW-1:0] acc_wdata,
    input  logic          upd_en,
    input  logic          flg_we,
    input  logic [DW-1:0] flg_wdata,
    output logic [DW-1:0] acc_out,
    output logic [DW-1:0] flg_out,
    output logic          alt_sel
);
    logic  sel;
    logic  zero_f, sign_f;
    pair_t pairs [NBANK];

    bankacc_bank_sel u_sel (
        .clk   (clk),
        .rst_n (rst_n),
        .xchg  (xchg),
        .sel   (sel)
    );

    bankacc_flaggen u_fgen (
        .result (acc_wdata),
        .zero_f (zero_f),
        .sign_f (sign_f)
    );

    for (genvar b = 0; b < NBANK; b++) begin : g_pair
        logic hit;
        assign hit = (sel == b[0]);
        bankacc_pair u_pair (
            .clk       (clk),
            .rst_n     (rst_n),
            .acc_we    (acc_we && hit),
            .acc_wdata (acc_wdata),
            .upd_en    (upd_en),
            .zero_f    (zero_f),
            .sign_f    (sign_f),
            .flg_we    (flg_we && hit),
            .flg_wdata (flg_wdata),
            .pair      (pairs[b])
        );
    end

    always_comb begin
        acc_out = pairs[sel].acc;
        flg_out = pairs[sel].flg;
        alt_sel = sel;
    end

    AST_ACC_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_we && !xchg) |=> (acc_out == $past(acc_wdata)));   // R2
    AST_SWAP_WRITE_OLD: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_we && xchg) |=> (pairs[!alt_sel].acc == $past(acc_wdata))); // R6
    AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_we && upd_en && !flg_we && !xchg) |=>
            (flg_out[ZERO_BIT] == (acc_out == '0)));            // R7
    AST_SIGN_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_we && upd_en && !flg_we && !xchg) |=>
            (flg_out[SIGN_BIT] == acc_out[DW-1]));              // R8
endmodule

// File: tb/bankacc_top_bench.sv
module bankacc_top_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       xchg = 1'b0, acc_we = 1'b0, upd_en = 1'b0, flg_we = 1'b0;
    logic [7:0] acc_wdata = '0, flg_wdata = '0;
    logic [7:0] acc_out, flg_out;
    logic       alt_sel;
    int         n_cmp = 0, n_bad = 0;

    always #5 clk = ~clk;

    bankacc_top u_bankacc_top (
        .clk(clk), .rst_n(rst_n), .xchg(xchg), .acc_we(acc_we),
        .acc_wdata(acc_wdata), .upd_en(upd_en), .flg_we(flg_we),
        .flg_wdata(flg_wdata), .acc_out(acc_out), .flg_out(flg_out),
        .alt_sel(alt_sel)
    );

    // {tag[3:0], xchg, acc_we, acc_wdata, upd_en, flg_we, flg_wdata, exp_sel, exp_acc, exp_flg}
    localparam int NV = 16;
    localparam logic [40:0] VEC [NV] = '{
        {4'd2,  1'b0, 1'b1, 8'h3C, 1'b0, 1'b0, 8'h00, 1'b0, 8'h3C, 8'h00},
        {4'd3,  1'b0, 1'b0, 8'h00, 1'b0, 1'b1, 8'h15, 1'b0, 8'h3C, 8'h15},
        {4'd7,  1'b0, 1'b1, 8'h00, 1'b1, 1'b0, 8'h00, 1'b0, 8'h00, 8'h55},
        {4'd8,  1'b0, 1'b1, 8'h80, 1'b1, 1'b0, 8'h00, 1'b0, 8'h80, 8'h95},
        {4'd4,  1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 8'h00, 1'b1, 8'h00, 8'h00},
        {4'd7,  1'b0, 1'b1, 8'h7F, 1'b1, 1'b0, 8'h00, 1'b1, 8'h7F, 8'h00},
        {4'd9,  1'b0, 1'b1, 8'h00, 1'b1, 1'b1, 8'hFF, 1'b1, 8'h00, 8'hFF},
        {4'd6,  1'b1, 1'b1, 8'h11, 1'b0, 1'b0, 8'h00, 1'b0, 8'h80, 8'h95},
        {4'd5,  1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 8'h00, 1'b1, 8'h11, 8'hFF},
        {4'd6,  1'b1, 1'b0, 8'h00, 1'b0, 1'b1, 8'h02, 1'b0, 8'h80, 8'h95},
        {4'd5,  1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 8'h00, 1'b1, 8'h11, 8'h02},
        {4'd8,  1'b0, 1'b1, 8'hC0, 1'b1, 1'b0, 8'h00, 1'b1, 8'hC0, 8'h82},
        {4'd10, 1'b0, 1'b1, 8'h01, 1'b0, 1'b0, 8'h00, 1'b1, 8'h01, 8'h82},
        {4'd5,  1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 8'h00, 1'b1, 8'h01, 8'h82},
        {4'd4,  1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0, 8'h80, 8'h95},
        {4'd4,  1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 8'h00, 1'b1, 8'h01, 8'h82}
    };

    function automatic string tag_name(input logic [3:0] t);
        case (t)
            4'd1: return "R1";   4'd2: return "R2";   4'd3: return "R3";
            4'd4: return "R4";   4'd5: return "R5";   4'd6: return "R6";
            4'd7: return "R7";   4'd8: return "R8";   4'd9: return "R9";
            default: return "R10";
        endcase
    endfunction

    task automatic check(input string req, input string what,
                         input logic [7:0] act, input logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic check_all(input string req, input logic s,
                             input logic [7:0] a, input logic [7:0] f);
        check(req, "alt_sel", {7'd0, alt_sel}, {7'd0, s});
        check(req, "acc_out", acc_out, a);
        check(req, "flg_out", flg_out, f);
    endtask

    task automatic drive(input logic x, input logic aw, input logic [7:0] ad,
                         input logic ue, input logic fw, input logic [7:0] fd);
        xchg = x; acc_we = aw; acc_wdata = ad; upd_en = ue; flg_we = fw; flg_wdata = fd;
    endtask

    initial begin : watchdog
        #2_000_000;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin : stim
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R1", 1'b0, 8'h00, 8'h00);   // R1 main pair, cleared

        for (int i = 0; i < NV; i++) begin
            drive(VEC[i][36], VEC[i][35], VEC[i][34:27], VEC[i][26],
                  VEC[i][25], VEC[i][24:17]);
            @(negedge clk);
            drive(1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 8'h00);
            check_all(tag_name(VEC[i][40:37]), VEC[i][16], VEC[i][15:8], VEC[i][7:0]);
        end

        // R1: mid-run reset clears both pairs and returns to main
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R1", 1'b0, 8'h00, 8'h00);
        drive(1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 8'h00);
        @(negedge clk);
        drive(1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 8'h00);
        check_all("R1", 1'b1, 8'h00, 8'h00);

        // R5: idle cycles leave the alternate pair intact after writes to main
        drive(1'b1, 1'b1, 8'hA5, 1'b1, 1'b0, 8'h00);  // write alt (0xA5 -> flg 0x80), swap to main
        @(negedge clk);
        drive(1'b0, 1'b1, 8'h00, 1'b1, 1'b0, 8'h00);  // main: acc 00, flg 0x40
        @(negedge clk);
        drive(1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 8'h00);
        check_all("R7", 1'b0, 8'h00, 8'h40);
        repeat (3) @(negedge clk);
        drive(1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 8'h00);
        @(negedge clk);
        drive(1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 8'h00);
        check_all("R5", 1'b1, 8'hA5, 8'h80);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule